// File: doc/BRIEF.md
# Boot ROM Patch Trap Unit

This block lets firmware patch code that sits in a boot ROM. It holds a bank of thirty programmable 32-bit trap addresses, and each one has its own enable bit. It watches the instruction-fetch address bus on its way to the ROM. When a valid fetch hits an enabled trap address, the block raises a bus-fault pulse in the same cycle. The exception handler can then steer execution to replacement code kept elsewhere.

A sticky fault status register records which trap entry caused the fault, so the handler can find the right patch. Software clears it in one of two ways: it writes a 1 to a dedicated clear register, or it writes a 0 to the flag bit itself. A plain register port gives access to the entries and the enables. The port takes a write strobe with an address and data, and its read data is combinational on the address.

The fetch side has no back-pressure. A fetch is observed in every cycle in which its valid strobe is high, and the block never stalls it. The fault is only an indication to the bus fabric, which owns the handshake with the core.

Top module: `rom_patch_trap`

## Requirements
- R1: After reset, every trap entry, the enable register and the fault status register read 0, and no fetch raises a fault.
- R2: The register at offset 4*n (n = 0..29) holds trap entry n as a full 32-bit value and reads back what was written. The enable register at offset 0x78 holds enable bit n in bit n. Bits 31:30 of the enable register read 0 whatever was written.
- R3: A fault is raised when fetch_valid is high, fetch_addr equals entry n and enable bit n is set. bus_fault is then high in that same cycle, with no register stage in between.
- R4: bus_fault stays low while fetch_valid is low, when the matching entry's enable bit is clear, and when no entry equals the address.
- R5: A fault that occurs while the error flag is clear sets the flag. From the next cycle, the status register at offset 0x7C reads bit 0 = 1 and bits 5:1 = the index of the entry that matched.
- R6: When several enabled entries match the same fetch, the lowest-numbered entry is the one recorded.
- R7: While the flag is set, a new match still raises bus_fault but leaves the recorded index unchanged.
- R8: A write to offset 0xA8 with bit 0 = 1 clears the flag. With bit 0 = 0 the write has no effect. The index field keeps its value when the flag is cleared.
- R9: A write to offset 0x7C with bit 0 = 0 clears the flag. With bit 0 = 1 the write has no effect. Bits 5:1 cannot be written.
- R10: If a fault occurs in the same cycle as a clear, the fault wins. The flag stays set and the new entry's index is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| fetch_valid | input | 1 | A fetch is on the ROM address bus this cycle |
| fetch_addr | input | 32 | Fetch address |
| bus_fault | output | 1 | Fault pulse for a fetch that hit an enabled entry |

## Verification
Two enabled entries are given the same address. A design with the wrong priority would then report the higher index, and a design that merged the hits would report a garbled one. The bench sends a second fetch that hits while the flag is already set, which catches a design that lets the index be overwritten. A fetch that matches a disabled entry catches a design that ignores the enables, and a matching address with fetch_valid low catches one that ignores the strobe. Both clear paths are tried with the inert data value as well as the clearing one. A fault is also raised in the very cycle of a clear, which exposes a design that lets the clear win and loses the event. A wide write to the status register shows whether the index field could be written.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int unsigned REG_AW   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 8'h78;
  localparam logic [REG_AW-1:0] OFS_STATUS = 8'h7C;
  localparam logic [REG_AW-1:0] OFS_CLEAR  = 8'hA8;
endpackage

// File: rtl/trap_regs.sv
module trap_regs #(
  parameter int unsigned N   = 30,
  parameter int unsigned DW  = 32,
  parameter int unsigned RAW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [RAW-1:0]        waddr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [RAW-1:0]        en_ofs_i,
  output logic [N-1:0][DW-1:0]  entries_o,
  output logic [N-1:0]          en_o
);
  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entries_o[g] <= '0;
      else if (wr_i && waddr_i == RAW'(4 * g)) entries_o[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= '0;
    else if (wr_i && waddr_i == en_ofs_i) en_o <= wdata_i[N-1:0];
  end

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/trap_match.sv
module trap_match #(
  parameter int unsigned N  = 30,
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_valid_i,
  input  logic [DW-1:0]        fetch_addr_i,
  input  logic [N-1:0][DW-1:0] entries_i,
  input  logic [N-1:0]         en_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  logic [N-1:0] hits;
  logic [N-1:0] grant;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = fetch_valid_i && en_i[g] && (entries_i[g] == fetch_addr_i);
  end

  // isolate lowest set bit: lowest entry wins
  assign grant = hits & (~hits + N'(1));
  assign hit_o = |hits;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx_o = idx_o | IW'(i);
    end
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (hit_o == (grant != '0)));
  // R4
  fault_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> fetch_valid_i);
endmodule

// File: rtl/trap_status.sv
module trap_status #(
  parameter int unsigned IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [IW-1:0] idx_i,
  input  logic          clr_i,
  output logic          flag_o,
  output logic [IW-1:0] idx_o
);
  logic flag_kept;
  assign flag_kept = flag_o && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      idx_o  <= '0;
    end else begin
      flag_o <= flag_kept || hit_i;
      if (hit_i && !flag_kept) idx_o <= idx_i;
    end
  end

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && (!flag_o || clr_i) |=> flag_o && idx_o == $past(idx_i));
  // R7
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o && $stable(idx_o));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !hit_i |=> !flag_o);
endmodule

// File: rtl/rom_patch_trap.sv
module rom_patch_trap
  import rpt_pkg::*;
#(
  parameter int unsigned N = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_addr,
  output logic              bus_fault
);
  localparam int unsigned IW = $clog2(N);

  logic [N-1:0][DATA_W-1:0] entries;
  logic [N-1:0]             en;
  logic                     hit;
  logic [IW-1:0]            hit_idx;
  logic                     flag;
  logic [IW-1:0]            rec_idx;
  logic                     clr;

  trap_regs #(.N(N), .DW(DATA_W), .RAW(REG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_we), .waddr_i(reg_addr),
    .wdata_i(reg_wdata), .en_ofs_i(OFS_ENABLE),
    .entries_o(entries), .en_o(en)
  );

  trap_match #(.N(N), .DW(DATA_W), .IW(IW)) match_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid_i(fetch_valid),
    .fetch_addr_i(fetch_addr), .entries_i(entries), .en_i(en),
    .hit_o(hit), .idx_o(hit_idx)
  );

  // two clear paths: write-1 at clear offset, write-0 to the flag
  assign clr = reg_we && ((reg_addr == OFS_CLEAR && reg_wdata[0]) ||
                          (reg_addr == OFS_STATUS && !reg_wdata[0]));

  trap_status #(.IW(IW)) status_i (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .idx_i(hit_idx), .clr_i(clr),
    .flag_o(flag), .idx_o(rec_idx)
  );

  assign bus_fault = hit;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_ENABLE) begin
      reg_rdata[N-1:0] = en;
    end else if (reg_addr == OFS_STATUS) begin
      reg_rdata[IW:1] = rec_idx;
      reg_rdata[0]    = flag;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (reg_addr == REG_AW'(4 * i)) reg_rdata = entries[i];
      end
    end
  end

  // R3
  fault_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |=> flag);
endmodule

// File: tb/rom_patch_trap_tb_top.sv
module rom_patch_trap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        bus_fault;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_fault;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  rom_patch_trap dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .bus_fault(bus_fault)
  );

  task automatic drive(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input bit fv, input logic [31:0] fa);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d;
    fetch_valid = fv; fetch_addr = fa;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0, '0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    drive(1'b0, a, '0, 1'b0, '0);
    sb_q.push_back('{1'b0, e, t});
  endtask

  task automatic fe(input logic [31:0] fa, input bit fv, input bit e, input string t);
    drive(1'b0, 8'h00, '0, fv, fa);
    sb_q.push_back('{1'b1, {31'b0, e}, t});
  endtask

  // monitor: samples 2 ns after the falling edge, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_fault ? {31'b0, bus_fault} : reg_rdata;
        total++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, 32'h0, "R1 entry0");
    rd(8'h74, 32'h0, "R1 entry29");
    rd(8'h78, 32'h0, "R1 enable");
    rd(8'h7C, 32'h0, "R1 status");
    fe(32'h0, 1'b1, 1'b0, "R1 no fault after reset");
    // R2 programming
    wr(8'h00, 32'h0000_1000);
    wr(8'h14, 32'h0000_2000);
    wr(8'h1C, 32'h0000_2000);
    wr(8'h30, 32'hDEAD_BEE0);
    wr(8'h74, 32'hFFFF_FFFC);
    rd(8'h14, 32'h0000_2000, "R2 entry5");
    rd(8'h74, 32'hFFFF_FFFC, "R2 entry29");
    wr(8'h78, 32'hFFFF_FFFF);
    rd(8'h78, 32'h3FFF_FFFF, "R2 enable upper bits");
    wr(8'h78, 32'h2000_00A1);
    rd(8'h78, 32'h2000_00A1, "R2 enable readback");
    // R4 misses
    fe(32'h0000_1004, 1'b1, 1'b0, "R4 address miss");
    fe(32'h0000_1000, 1'b0, 1'b0, "R4 valid low");
    fe(32'hDEAD_BEE0, 1'b1, 1'b0, "R4 disabled entry");
    // R3 / R6: entries 5 and 7 both match
    fe(32'h0000_2000, 1'b1, 1'b1, "R3 fault same cycle");
    fe(32'h0000_0000, 1'b0, 1'b0, "R3 single cycle pulse");
    rd(8'h7C, 32'h0000_000B, "R6 lowest index 5");
    // R7 second hit while flag set
    fe(32'h0000_1000, 1'b1, 1'b1, "R7 fault while flagged");
    rd(8'h7C, 32'h0000_000B, "R7 index kept");
    // R8 clear register
    wr(8'hA8, 32'h0000_0000);
    rd(8'h7C, 32'h0000_000B, "R8 write 0 no effect");
    wr(8'hA8, 32'h0000_0001);
    rd(8'h7C, 32'h0000_000A, "R8 write 1 clears");
    // R5 highest entry
    fe(32'hFFFF_FFFC, 1'b1, 1'b1, "R5 fault entry29");
    rd(8'h7C, 32'h0000_003B, "R5 index 29 recorded");
    // R9 status write
    wr(8'h7C, 32'hFFFF_FFFF);
    rd(8'h7C, 32'h0000_003B, "R9 write 1 no effect");
    wr(8'h7C, 32'h0000_0000);
    rd(8'h7C, 32'h0000_003A, "R9 write 0 clears");
    // R10 fault coinciding with clear
    fe(32'hFFFF_FFFC, 1'b1, 1'b1, "R10 set flag");
    drive(1'b1, 8'hA8, 32'h1, 1'b1, 32'h0000_1000);
    sb_q.push_back('{1'b1, 32'h1, "R10 fault in clear cycle"});
    rd(8'h7C, 32'h0000_0001, "R10 fault wins index 0");
    // R6 with entry 5 disabled: entry 7 reported
    wr(8'h78, 32'h2000_0080);
    wr(8'hA8, 32'h1);
    fe(32'h0000_2000, 1'b1, 1'b1, "R6 entry7 fault");
    rd(8'h7C, 32'h0000_000F, "R6 index 7");
    drive(1'b0, 8'h00, '0, 1'b0, '0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule